// File: doc/BRIEF.md
# SPI Command Decoder with Protected Memory

This block is an SPI slave (mode 0) that takes one command per chip-select frame and turns it into register updates, status reads and accesses to a 512-byte nonvolatile-style byte array. The array is held in on-chip storage. Each frame opens with an 8-bit opcode. Memory commands then carry a 16-bit address. Register commands carry one data byte. Status reads stream their value back on the serial output.

Writes are guarded by a write-enable latch. Writes to the array are first gathered into a page buffer. They are committed by a self-timed write cycle that begins when chip select returns high. A busy flag marks that cycle, and software polls it with the memory-status read. A lock setting picks one of eight protection levels, and each level shields a region measured down from the top of the array. All SPI pins are sampled in the system clock domain, so SCK must be slow compared with that clock.

Top module: `spi_cmd_top`

## Requirements
- R1: SCK idles low. SI is sampled on SCK rising edges and SO changes after SCK falling edges, most significant bit first. SO is high impedance while CS is high. The first reply bit appears on the falling edge that follows the last command or address bit.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns a byte with bit 0 = write cycle busy, bit 1 = write-enable latch, and all other bits 0. The byte repeats for as long as the clock runs.
- R3: The write-type opcodes (0x02, 0x09, 0x0A, 0x01) have no effect while the write-enable latch is clear.
- R4: Opcode 0x09 loads the next byte into the configuration output. Opcode 0x0A loads the next byte into the control output. Either write clears the write-enable latch, and any later bytes in the same frame are ignored.
- R5: Opcode 0x0B shifts out the status input. It is sampled at the end of the opcode byte and again at each later byte boundary.
- R6: Opcode 0x03 plus a 16-bit address streams bytes from consecutive locations. Only the low 9 address bits are used and the upper bits are ignored. The stream wraps from 0x1FF to 0x000.
- R7: Opcode 0x02 plus a 16-bit address stores the following data bytes at incrementing addresses. The address wraps inside its 16-byte page (the low 4 bits roll over and the upper bits stay fixed).
- R8: The write cycle starts only when CS rises after at least one whole data byte, with CS rising on a byte boundary. Otherwise nothing is stored and the latch keeps its value. The busy flag then stays set for WRITE_CYCLES clocks, and the latch clears when the cycle ends.
- R9: While busy, every opcode except 0x05 is ignored.
- R10: Opcode 0x01 takes the low 3 bits of the next byte as lock level k and clears the write-enable latch. At k = 0 nothing is locked. For k = 1..7, addresses at or above 512 - (512 >> (7 - k)) are protected, and a write cycle leaves a protected byte unchanged.
- R11: A byte that is cut short by CS rising is discarded. A register or lock write that is missing bits does nothing.
- R12: After reset the configuration and control outputs are 0, the latch is clear, the lock level is 0, the array is all zeros and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | SPI serial clock |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSi | input | 1 | SPI serial data in |
| spiSo | output | 1 | SPI serial data out, high impedance when deselected |
| statusIn | input | 8 | Status value returned by opcode 0x0B |
| cfgOut | output | 8 | Configuration register |
| ctrlOut | output | 8 | Control register |

## Verification
Two functions can land in the same stretch of cycles: the self-timed commit, which steps through the page buffer and counts down busy, and the decoding of a new frame. The bench provokes the overlap by polling memory status at once after a burst write, which must report busy and latch both set. It then sends a configuration write while the cycle is still running, and that write must leave the output untouched. A behavioural model in the bench tracks the array, lock level, latch and registers, and compares the register outputs on every idle clock.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_MWRITE = 8'h02;
  localparam logic [7:0] OP_MSTAT  = 8'h05;
  localparam logic [7:0] OP_MREAD  = 8'h03;
  localparam logic [7:0] OP_WCFG   = 8'h09;
  localparam logic [7:0] OP_WCTRL  = 8'h0A;
  localparam logic [7:0] OP_RSTAT  = 8'h0B;
  localparam logic [7:0] OP_LOCK   = 8'h01;

  // strobes from the frame controller to the datapath
  typedef struct packed {
    logic        welSet;
    logic        welClr;
    logic        cfgWr;
    logic        ctrlWr;
    logic        lockWr;
    logic        txMemStat;
    logic        txStat;
    logic        rdStart;
    logic        rdNext;
    logic        wrStart;
    logic        wrByte;
    logic        wrCommit;
    logic        shiftOut;
    logic        idle;
    logic [7:0]  data;
    logic [15:0] addr;
  } dpStrobe_t;

endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      spiSck,
  input  logic      spiCsN,
  input  logic      spiSi,
  input  logic      busy,
  input  logic      wel,
  output dpStrobe_t strb
);

  logic       sckD, sckP, csD, csP, siD;
  logic [2:0] bitCnt;
  logic [2:0] byteCnt;
  logic [6:0] rxShift;
  logic [7:0] opReg;
  logic [7:0] addrHi;
  logic       accept;

  logic       sckRise, sckFall, csRise, byteDone, opAccept, isWrType;
  logic [7:0] rxByte;

  assign sckRise  = sckD & ~sckP & ~csD;
  assign sckFall  = ~sckD & sckP & ~csD;
  assign csRise   = csD & ~csP;
  assign rxByte   = {rxShift, siD};
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign isWrType = (rxByte == OP_MWRITE) || (rxByte == OP_WCFG) ||
                    (rxByte == OP_WCTRL)  || (rxByte == OP_LOCK);

  always_comb begin
    if (rxByte == OP_MSTAT)  opAccept = 1'b1;
    else if (isWrType)       opAccept = wel && !busy;
    else                     opAccept = !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckD    <= 1'b0;
      sckP    <= 1'b0;
      siD     <= 1'b0;
      csD     <= 1'b1;
      csP     <= 1'b1;
      bitCnt  <= '0;
      byteCnt <= '0;
      rxShift <= '0;
      opReg   <= '0;
      addrHi  <= '0;
      accept  <= 1'b0;
    end else begin
      sckD <= spiSck;
      sckP <= sckD;
      siD  <= spiSi;
      csD  <= spiCsN;
      csP  <= csD;
      if (csD) begin
        bitCnt  <= '0;
        byteCnt <= '0;
        accept  <= 1'b0;
      end else if (sckRise) begin
        bitCnt  <= bitCnt + 3'd1;
        rxShift <= rxByte[6:0];
        if (bitCnt == 3'd7) begin
          if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
          if (byteCnt == 3'd0) begin
            opReg  <= rxByte;
            accept <= opAccept;
          end
          if (byteCnt == 3'd1) addrHi <= rxByte;
        end
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.data     = rxByte;
    strb.addr     = {addrHi, rxByte};
    strb.shiftOut = sckFall;
    strb.idle     = csD;
    strb.wrCommit = csRise && accept && (opReg == OP_MWRITE) &&
                    (byteCnt >= 3'd4) && (bitCnt == 3'd0);
    if (byteDone) begin
      if (byteCnt == 3'd0) begin
        if (opAccept) begin
          case (rxByte)
            OP_WREN:  strb.welSet    = 1'b1;
            OP_WRDI:  strb.welClr    = 1'b1;
            OP_MSTAT: strb.txMemStat = 1'b1;
            OP_RSTAT: strb.txStat    = 1'b1;
            default: ;
          endcase
        end
      end else if (accept) begin
        if (opReg == OP_MSTAT) strb.txMemStat = 1'b1;
        if (opReg == OP_RSTAT) strb.txStat    = 1'b1;
        if (byteCnt == 3'd1) begin
          strb.cfgWr  = (opReg == OP_WCFG);
          strb.ctrlWr = (opReg == OP_WCTRL);
          strb.lockWr = (opReg == OP_LOCK);
        end else if (byteCnt == 3'd2) begin
          strb.rdStart = (opReg == OP_MREAD);
          strb.wrStart = (opReg == OP_MWRITE);
        end else begin
          strb.rdNext = (opReg == OP_MREAD);
          strb.wrByte = (opReg == OP_MWRITE);
        end
      end
    end
  end

  // R11: a byte cut short never yields a strobe after deselect
  a_r11_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    csP |-> !(strb.cfgWr || strb.ctrlWr || strb.lockWr || strb.wrByte));

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 600
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strb,
  input  logic [7:0] statusIn,
  output logic      wel,
  output logic      busy,
  output logic      soBit,
  output logic [7:0] cfgOut,
  output logic [7:0] ctrlOut
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [7:0]        mem [MEM_BYTES];
  logic [7:0]        pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [BASE_W-1:0] pageBase;
  logic [PAGE_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [2:0]        lockCfg;
  logic [CNT_W-1:0]  busyCnt;
  logic [PAGE_W:0]   cmtIdx;
  logic [7:0]        txShift;
  logic [7:0]        cfgReg, ctrlReg;

  logic [ADDR_W-1:0] cmtAddr;
  logic              memWe;

  function automatic logic isLocked(input logic [ADDR_W-1:0] a, input logic [2:0] k);
    int floorA;
    floorA = MEM_BYTES - (MEM_BYTES >> (3'd7 - k));
    return (k != 3'd0) && (int'(a) >= floorA);
  endfunction

  assign cmtAddr = {pageBase, cmtIdx[PAGE_W-1:0]};
  assign memWe   = busy && !cmtIdx[PAGE_W] && pageMask[cmtIdx[PAGE_W-1:0]] &&
                   !isLocked(cmtAddr, lockCfg);
  assign cfgOut  = cfgReg;
  assign ctrlOut = ctrlReg;

  // registers and write-enable latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel     <= 1'b0;
      cfgReg  <= '0;
      ctrlReg <= '0;
      lockCfg <= '0;
    end else begin
      if (strb.cfgWr)  cfgReg  <= strb.data;
      if (strb.ctrlWr) ctrlReg <= strb.data;
      if (strb.lockWr) lockCfg <= strb.data[2:0];
      if (strb.welSet) wel <= 1'b1;
      else if (strb.welClr || strb.cfgWr || strb.ctrlWr || strb.lockWr ||
               (busy && busyCnt == '0)) wel <= 1'b0;
    end
  end

  // page buffer gathering a burst
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageMask <= '0;
      pageBase <= '0;
      wrPtr    <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (strb.wrStart) begin
      pageMask <= '0;
      pageBase <= strb.addr[ADDR_W-1:PAGE_W];
      wrPtr    <= strb.addr[PAGE_W-1:0];
    end else if (strb.wrByte) begin
      pageBuf[wrPtr]  <= strb.data;
      pageMask[wrPtr] <= 1'b1;
      wrPtr           <= wrPtr + 1'b1;
    end
  end

  // self-timed write cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
      cmtIdx  <= '0;
    end else if (strb.wrCommit) begin
      busy    <= 1'b1;
      busyCnt <= CNT_W'(WRITE_CYCLES - 1);
      cmtIdx  <= '0;
    end else if (busy) begin
      if (!cmtIdx[PAGE_W]) cmtIdx <= cmtIdx + 1'b1;
      if (busyCnt == '0) busy <= 1'b0;
      else               busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (memWe) begin
      mem[cmtAddr] <= pageBuf[cmtIdx[PAGE_W-1:0]];
    end
  end

  // serial output path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      soBit   <= 1'b0;
      rdPtr   <= '0;
    end else if (strb.idle) begin
      txShift <= '0;
      soBit   <= 1'b0;
    end else if (strb.shiftOut) begin
      soBit   <= txShift[7];
      txShift <= {txShift[6:0], 1'b0};
    end else if (strb.txMemStat) begin
      txShift <= {6'b0, wel, busy};
    end else if (strb.txStat) begin
      txShift <= statusIn;
    end else if (strb.rdStart) begin
      txShift <= mem[strb.addr[ADDR_W-1:0]];
      rdPtr   <= strb.addr[ADDR_W-1:0] + 1'b1;
    end else if (strb.rdNext) begin
      txShift <= mem[rdPtr];
      rdPtr   <= rdPtr + 1'b1;
    end
  end

  a_r2_wel_from_wren: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(strb.welSet));
  a_r3_cfg_guarded: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgReg) |-> $past(wel));
  a_r8_busy_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.wrCommit));
  a_r8_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);
  a_r9_regs_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(cfgReg) && $stable(ctrlReg) && $stable(lockCfg)));

endmodule

// File: rtl/spi_cmd_top.sv
module spi_cmd_top
  import spi_cmd_pkg::*;
#(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSck,
  input  logic       spiCsN,
  input  logic       spiSi,
  output logic       spiSo,
  input  logic [7:0] statusIn,
  output logic [7:0] cfgOut,
  output logic [7:0] ctrlOut
);

  dpStrobe_t strb;
  logic      wel, busy, soBit;

  spi_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .busy(busy), .wel(wel), .strb(strb)
  );

  spi_cmd_dp #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .statusIn(statusIn),
    .wel(wel), .busy(busy), .soBit(soBit), .cfgOut(cfgOut), .ctrlOut(ctrlOut)
  );

  assign spiSo = spiCsN ? 1'bz : soBit;

endmodule

// File: tb/tb_spi_cmd_top.sv
`timescale 1ns/1ps
module tb_spi_cmd_top;

  localparam int WC = 600;

  logic clk = 1'b0, rstN = 1'b0;
  logic spiSck = 1'b0, spiCsN = 1'b1, spiSi = 1'b0;
  logic [7:0] statusIn = 8'h00;
  wire  spiSo;
  logic [7:0] cfgOut, ctrlOut;

  spi_cmd_top #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiSo(spiSo), .statusIn(statusIn), .cfgOut(cfgOut), .ctrlOut(ctrlOut)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit inXfer = 1;

  logic [7:0] refMem [512];
  logic [7:0] refCfg = 0, refCtrl = 0;
  logic [2:0] refLock = 0;
  logic [7:0] txBuf [8];
  logic [7:0] rxBuf [8];
  logic [7:0] wdat [4];

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // model compared on every idle clock
  always @(negedge clk) begin
    if (rstN && !inXfer && !done) begin
      check("R4 cfgOut", cfgOut, refCfg);
      check("R4 ctrlOut", ctrlOut, refCtrl);
      checks++;
      if (spiSo !== 1'bz) begin
        errors++;
        $display("FAIL R1 SO while deselected got %b expected z", spiSo);
      end
    end
  end

  function automatic bit refLocked(int a);
    return (refLock != 0) && (a >= 512 - (512 >> (7 - refLock)));
  endfunction

  task automatic xfer(int nBits);
    @(posedge clk); inXfer = 1;
    @(negedge clk); spiCsN = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      spiSi = txBuf[i/8][7-(i%8)];
      repeat (4) @(negedge clk);
      rxBuf[i/8][7-(i%8)] = spiSo;
      spiSck = 1;
      repeat (4) @(negedge clk);
      spiSck = 0;
    end
    repeat (4) @(negedge clk);
    spiCsN = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic resume();
    @(posedge clk); inXfer = 0;
  endtask

  task automatic op1(logic [7:0] op);
    txBuf[0] = op; xfer(8); resume();
  endtask

  task automatic memStat(output logic [7:0] v);
    txBuf[0] = 8'h05; txBuf[1] = 0; txBuf[2] = 0; xfer(24); resume();
    v = rxBuf[1];
    check("R2 status repeat", rxBuf[2], rxBuf[1]);
  endtask

  task automatic regWrite(logic [7:0] op, logic [7:0] v, int nBits);
    txBuf[0] = op; txBuf[1] = v; txBuf[2] = 8'hFF; xfer(nBits);
  endtask

  task automatic memWrite(logic [15:0] a, int n);
    txBuf[0] = 8'h02; txBuf[1] = a[15:8]; txBuf[2] = a[7:0];
    for (int i = 0; i < n; i++) txBuf[3+i] = wdat[i];
    xfer(24 + 8*n);
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = {a[8:4], 4'(a[3:0] + i)};
      if (!refLocked(ad)) refMem[ad] = wdat[i];
    end
    resume();
  endtask

  task automatic memRead(logic [15:0] a, int n, string req);
    txBuf[0] = 8'h03; txBuf[1] = a[15:8]; txBuf[2] = a[7:0];
    for (int i = 3; i < 8; i++) txBuf[i] = 8'h00;
    xfer(24 + 8*n); resume();
    for (int i = 0; i < n; i++) check(req, rxBuf[3+i], refMem[(a[8:0] + i) % 512]);
  endtask

  task automatic waitCycle();
    repeat (WC + 20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got hang expected finish");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 512; i++) refMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 cfg reset", cfgOut, 8'h00);
    check("R12 ctrl reset", ctrlOut, 8'h00);
    resume();
    memStat(v); check("R12 status after reset", v, 8'h00);

    // R3 write without latch
    regWrite(8'h09, 8'h77, 16); resume();
    check("R3 cfg unchanged", cfgOut, 8'h00);

    // R2 latch set and clear
    op1(8'h06); memStat(v); check("R2 latch set", v, 8'h02);
    op1(8'h04); memStat(v); check("R2 latch clear", v, 8'h00);

    // R4 register writes
    op1(8'h06); regWrite(8'h09, 8'h5A, 24); refCfg = 8'h5A; resume();
    memStat(v); check("R4 latch cleared by cfg write", v, 8'h00);
    op1(8'h06); regWrite(8'h0A, 8'hC3, 16); refCtrl = 8'hC3; resume();
    check("R4 ctrl value", ctrlOut, 8'hC3);

    // R5 status read
    statusIn = 8'hA5;
    txBuf[0] = 8'h0B; txBuf[1] = 0; txBuf[2] = 0; xfer(24); resume();
    check("R5 status byte0", rxBuf[1], 8'hA5);
    check("R5 status byte1", rxBuf[2], 8'hA5);

    // R7 page wrap burst, R8/R9 overlap with busy
    op1(8'h06);
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h44;
    memWrite(16'h001E, 4);
    memStat(v); check("R8 busy and latch during cycle", v, 8'h03);
    regWrite(8'h09, 8'h99, 16); resume();
    check("R9 cfg ignored while busy", cfgOut, refCfg);
    waitCycle();
    memStat(v); check("R8 latch cleared after cycle", v, 8'h00);
    memRead(16'hFE1E, 4, "R6 R7 read with upper address bits");
    memRead(16'h0010, 2, "R7 wrapped bytes");

    // R6 wrap at end of array
    op1(8'h06); wdat[0] = 8'h99; memWrite(16'h01FF, 1); waitCycle();
    memRead(16'h01FF, 2, "R6 array wrap");

    // R11/R8 partial frames
    op1(8'h06);
    txBuf[0] = 8'h02; txBuf[1] = 8'h00; txBuf[2] = 8'h40; txBuf[3] = 8'h5A; txBuf[4] = 8'hF0;
    xfer(36); resume();
    memStat(v); check("R8 no cycle on partial byte", v, 8'h02);
    memRead(16'h0040, 1, "R11 partial write stored nothing");
    regWrite(8'h09, 8'hE7, 13); resume();
    check("R11 partial cfg write", cfgOut, refCfg);
    memStat(v); check("R11 latch kept", v, 8'h02);

    // R10 lock levels
    regWrite(8'h01, 8'h06, 16); refLock = 3'd6; resume();
    memStat(v); check("R10 lock clears latch", v, 8'h00);
    op1(8'h06); wdat[0] = 8'hAB; memWrite(16'h0100, 1); waitCycle();
    memRead(16'h0100, 1, "R10 protected byte unchanged");
    op1(8'h06); wdat[0] = 8'hCD; memWrite(16'h00FF, 1); waitCycle();
    memRead(16'h00FF, 1, "R10 byte below boundary written");
    op1(8'h06); regWrite(8'h01, 8'h07, 16); refLock = 3'd7; resume();
    op1(8'h06); wdat[0] = 8'h5C; memWrite(16'h001E, 1); waitCycle();
    memRead(16'h001E, 1, "R10 full lock");
    op1(8'h06); regWrite(8'h01, 8'h00, 16); refLock = 3'd0; resume();
    op1(8'h06); wdat[0] = 8'hEE; memWrite(16'h01F8, 1); waitCycle();
    memRead(16'h01F8, 1, "R10 unlocked write");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule